// File: doc/BRIEF.md
# Synchronous Serial Master Port with Completion and Collision Flags

This block is an 8-bit master-only synchronous serial shifter. It is driven through a small register window with three registers: control, status and data. Writing the data register while the port is idle loads the outgoing byte and starts a transfer. The port then produces a serial clock, shifts the byte out most significant bit first, and shifts in the byte returned by the remote device. The serial clock is derived from the system clock by one of four power-of-two dividers.

Two status flags report the state of the port. The completion flag rises on the eighth rising serial-clock edge. The collision flag records a data-register access made while the shifter is busy. Software clears both flags with an ordered handshake: a status read that finds the completion flag set, followed by a data-register read or write. The completion flag can also be cleared directly through a write-one-to-clear control bit. An interrupt request follows the completion flag when interrupts are enabled.

Top module: `ssp_port`

## Requirements
- R1: After synchronous reset the status register reads 0x00, the interrupt request is low and the serial clock output is high.
- R2: The register window has control at address 0, status at address 1 and data at address 2. Read data appears on `rdata` one clock after the access is presented. Status bit 7 is the completion flag, bit 6 is the collision flag, and bits 5..0 read 0. Control bit 7 enables the interrupt, control bit 4 is write-one-to-clear for the completion flag and reads 0, and control bits 1..0 select the rate.
- R3: A data write while idle starts a transfer. The serial clock idles high. The output bit changes on each falling edge, most significant bit first. The input bit is sampled on each rising edge. A transfer lasts eight serial-clock periods.
- R4: The serial-clock period is 64, 32, 16 or 8 system clocks for rate select 00, 01, 10 or 11 respectively.
- R5: The completion flag is set on the eighth rising serial-clock edge, and a data read then returns the byte received in that transfer.
- R6: A status read that finds the completion flag set, followed by a data read or write, clears the completion flag.
- R7: A data read not preceded by such a status read leaves the completion flag set.
- R8: Writing control with bit 4 at 1 clears the completion flag.
- R9: If the completion flag is cleared while a transfer is running, it is set again at the end of that transfer.
- R10: A data read or write while a transfer runs, after its first falling serial-clock edge, sets the collision flag. An access before the first falling edge does not set it.
- R11: The clearing handshake of R6 also clears the collision flag. If the completing data access itself falls after the first falling edge of a running transfer, the collision flag is set again.
- R12: The interrupt request is high exactly when the completion flag is set and control bit 7 is 1.
- R13: A data write during a running transfer does not change the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Transfers are run with outgoing and returned bytes 0xA5/0x3C, 0x00/0xFF, 0xFF/0x00 and others. All-zero and all-one bytes show whether bit order and sampling edges are correct, and mixed patterns expose swapped or shifted bits. The flag handshake is tried in four forms: complete, data access alone, control-bit clear, and clear in the middle of a transfer. Each form separates clearing that depends on order from clearing by any access. Data accesses are placed before and after the first falling serial-clock edge, and the clearing access is placed inside a running transfer, to pin down the collision window. Each of the four rate codes is timed by counting system clocks between falling serial-clock edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int CTL_IE_BIT  = 7;
  localparam int CTL_CLR_BIT = 4;
  localparam int ST_DONE_BIT = 7;
  localparam int ST_COL_BIT  = 6;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int MIN_DIV = 8,
  parameter int RSEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic [RSEL_W-1:0] rate,
  output logic              tick
);
  localparam int NRATE   = 1 << RSEL_W;
  localparam int MAX_DIV = MIN_DIV << (NRATE - 1);
  localparam int CNT_W   = $clog2(MAX_DIV / 2);

  logic [RSEL_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;

  // half period for the latched rate, minus one
  always_comb begin
    int half;
    half = (MIN_DIV << ((NRATE - 1) - int'(rate_q))) / 2;
    lim  = CNT_W'(half - 1);
  end

  assign tick = run && !restart && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rate_q <= '0;
    end else if (restart) begin
      cnt    <= '0;
      rate_q <= rate;
    end else if (run) begin
      if (cnt == lim) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              sck,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_data,
  output logic              fell_seen,
  output logic              last_rise
);
  localparam int BC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [BC_W-1:0]   bitcnt;

  assign last_rise = busy && tick && !sck && (bitcnt == BC_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sck       <= 1'b1;
      sdo       <= 1'b0;
      shreg     <= '0;
      rx_data   <= '0;
      bitcnt    <= '0;
      fell_seen <= 1'b0;
    end else if (start) begin
      shreg     <= tx_data;
      busy      <= 1'b1;
      bitcnt    <= '0;
      fell_seen <= 1'b0;
      sck       <= 1'b1;
    end else if (busy && tick) begin
      if (sck) begin
        sck       <= 1'b0;
        sdo       <= shreg[DATA_W-1];
        fell_seen <= 1'b1;
      end else begin
        sck    <= 1'b1;
        shreg  <= {shreg[DATA_W-2:0], sdi};
        bitcnt <= bitcnt + 1'b1;
        if (last_rise) begin
          busy    <= 1'b0;
          rx_data <= {shreg[DATA_W-2:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic w1c,
  input  logic done_evt,
  input  logic col_evt,
  output logic done,
  output logic col,
  output logic armed
);
  logic seq_clr;

  assign seq_clr = data_acc && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      col   <= 1'b0;
      armed <= 1'b0;
    end else begin
      // status read arms on a set flag, disarms on a clear one
      if (stat_rd)      armed <= done;
      else if (seq_clr) armed <= 1'b0;

      if (done_evt)              done <= 1'b1;
      else if (seq_clr || w1c)   done <= 1'b0;

      if (col_evt)      col <= 1'b1;
      else if (seq_clr) col <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_DIV = 8,
  parameter int RSEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi
);
  reg_addr_e         ra;
  logic [DATA_W-1:0] ctrl_q;
  logic              ie;
  logic [RSEL_W-1:0] rate;
  logic              data_acc, stat_rd, ctrl_wr, w1c, start;
  logic              busy, fell_seen, last_rise, tick;
  logic              done, col, armed, col_evt;
  logic [DATA_W-1:0] rx_data;

  assign ra       = reg_addr_e'(addr);
  assign data_acc = sel && (ra == REG_DATA);
  assign stat_rd  = sel && !we && (ra == REG_STAT);
  assign ctrl_wr  = sel && we && (ra == REG_CTRL);
  assign w1c      = ctrl_wr && wdata[CTL_CLR_BIT];
  assign start    = data_acc && we && !busy;
  assign col_evt  = data_acc && busy && fell_seen;
  assign ie       = ctrl_q[CTL_IE_BIT];
  assign rate     = ctrl_q[RSEL_W-1:0];
  assign irq      = done && ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q              <= wdata;
      ctrl_q[CTL_CLR_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !we) begin
      unique case (ra)
        REG_CTRL: rdata <= ctrl_q;
        REG_STAT: begin
          rdata              <= '0;
          rdata[ST_DONE_BIT] <= done;
          rdata[ST_COL_BIT]  <= col;
        end
        REG_DATA: rdata <= rx_data;
        default:  rdata <= '0;
      endcase
    end
  end

  ssp_baud #(.MIN_DIV(MIN_DIV), .RSEL_W(RSEL_W)) u_baud (
    .clk(clk), .rst(rst), .restart(start), .run(busy), .rate(rate), .tick(tick)
  );

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_data(wdata), .tick(tick), .sdi(sdi),
    .busy(busy), .sck(sck), .sdo(sdo), .rx_data(rx_data),
    .fell_seen(fell_seen), .last_rise(last_rise)
  );

  ssp_flags u_flags (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_acc(data_acc), .w1c(w1c),
    .done_evt(last_rise), .col_evt(col_evt),
    .done(done), .col(col), .armed(armed)
  );
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sck,
  input logic sdo,
  input logic last_rise,
  input logic done,
  input logic col,
  input logic armed,
  input logic data_acc,
  input logic w1c
);
  // R5: completion flag follows the final rising serial edge
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    last_rise |=> done);

  // R3: serial clock held high while idle
  a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck);

  // R3: output bit only moves on a falling edge
  a_r3_sdo_steady_high: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sck && $past(sck)) |-> $stable(sdo));

  // R6 / R8: completion flag drops only through handshake or control clear
  a_r6_done_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past((armed && data_acc) || w1c));

  // R10: collision flag rises only on a data access during a transfer
  a_r10_col_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(col) |-> $past(data_acc && busy));

  // R11: collision flag drops only through the armed handshake
  a_r11_col_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(col) |-> $past(armed && data_acc));
endmodule

bind ssp_port ssp_port_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sck(sck), .sdo(sdo),
  .last_rise(last_rise), .done(done), .col(col), .armed(armed),
  .data_acc(data_acc), .w1c(w1c)
);

// File: tb/sim_ssp_port.sv
`timescale 1ns/1ps
module sim_ssp_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, sck, sdo;
  logic       sdi = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0, xfer_cnt = 0, mon_n = 0;
  bit finished = 0;
  logic [7:0] mon_sh = 8'd0, slave_sh = 8'd0;
  logic [7:0] exp_q[$];
  logic [7:0] q;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  ssp_port u0 (.clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .sdo(sdo), .sdi(sdi));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // remote device: presents next bit on each falling edge
  always @(negedge sck) if (!rst) begin
    sdi      <= slave_sh[7];
    slave_sh <= {slave_sh[6:0], 1'b0};
  end

  // monitor: gathers outgoing bits on rising edges, compares with queue (R3, R13)
  always @(posedge sck) if (!rst) begin
    mon_sh = {mon_sh[6:0], sdo};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      if (exp_q.size() == 0) chk("R3 unexpected transfer", 1, 0);
      else chk("R3/R13 shifted-out byte", mon_sh, exp_q.pop_front());
      xfer_cnt++;
    end
  end

  task automatic bus(input logic w, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    r = rdata;
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] dummy;
    exp_q.push_back(tx);
    slave_sh = rx;
    bus(1'b1, 2'd2, tx, dummy);
  endtask

  task automatic wait_xfer();
    int target;
    target = xfer_cnt + 1 - exp_q.size() + exp_q.size();
    wait (xfer_cnt >= target);
    @(negedge clk);
  endtask

  task automatic wait_all();
    wait (exp_q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sck after reset", sck, 1);
    chk("R1 irq after reset", irq, 0);
    bus(1'b0, 2'd1, 8'h00, q); chk("R1 status after reset", q, 8'h00);

    // ie=1, rate 11
    bus(1'b1, 2'd0, 8'h83, q);
    bus(1'b0, 2'd0, 8'h00, q); chk("R2 control readback", q, 8'h83);
    start_xfer(8'hA5, 8'h3C); wait_all();
    chk("R12 irq with enable", irq, 1);
    bus(1'b0, 2'd1, 8'h00, q); chk("R2 R5 status done", q, 8'h80);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received byte", q, 8'h3C);
    bus(1'b0, 2'd1, 8'h00, q); chk("R6 cleared by handshake", q, 8'h00);
    chk("R12 irq after clear", irq, 0);

    start_xfer(8'h00, 8'hFF); wait_all();
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received all ones", q, 8'hFF);
    bus(1'b0, 2'd1, 8'h00, q); chk("R7 data read alone keeps flag", q, 8'h80);
    bus(1'b1, 2'd0, 8'h93, q);
    bus(1'b0, 2'd1, 8'h00, q); chk("R8 control clear", q, 8'h00);
    bus(1'b0, 2'd0, 8'h00, q); chk("R2 clear bit reads zero", q, 8'h83);

    // interrupt disabled
    bus(1'b1, 2'd0, 8'h03, q);
    start_xfer(8'hFF, 8'h00); wait_all();
    chk("R12 irq masked", irq, 0);
    bus(1'b0, 2'd1, 8'h00, q); chk("R5 status done masked", q, 8'h80);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received all zeros", q, 8'h00);
    bus(1'b1, 2'd0, 8'h83, q);

    // R9: clear in mid transfer, set again at end
    start_xfer(8'h3C, 8'hC3);
    repeat (20) @(negedge clk);
    bus(1'b1, 2'd0, 8'h93, q);
    bus(1'b0, 2'd1, 8'h00, q); chk("R9 cleared mid transfer", q, 8'h00);
    wait_all();
    bus(1'b0, 2'd1, 8'h00, q); chk("R9 set again at end", q, 8'h80);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received C3", q, 8'hC3);

    // R10: access before first falling edge is not a collision
    start_xfer(8'h81, 8'h7E);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 early read returns previous byte", q, 8'hC3);
    wait_all();
    bus(1'b0, 2'd1, 8'h00, q); chk("R10 no collision before first fall", q, 8'h80);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received 7E", q, 8'h7E);

    // R10 / R13: write during transfer
    start_xfer(8'h5A, 8'h96);
    repeat (20) @(negedge clk);
    bus(1'b1, 2'd2, 8'hEE, q);
    bus(1'b0, 2'd1, 8'h00, q); chk("R10 collision mid transfer", q, 8'h40);
    wait_all();
    bus(1'b0, 2'd1, 8'h00, q); chk("R10 collision and done", q, 8'hC0);
    bus(1'b0, 2'd2, 8'h00, q); chk("R13 received byte intact", q, 8'h96);
    bus(1'b0, 2'd1, 8'h00, q); chk("R11 both flags cleared", q, 8'h00);

    // R11: completing access lands inside a running transfer
    start_xfer(8'h11, 8'h22); wait_all();
    start_xfer(8'h33, 8'h44);
    repeat (20) @(negedge clk);
    bus(1'b0, 2'd1, 8'h00, q); chk("R11 done still set", q, 8'h80);
    bus(1'b0, 2'd2, 8'h00, q);
    bus(1'b0, 2'd1, 8'h00, q); chk("R11 collision set again", q, 8'h40);
    wait_all();
    bus(1'b0, 2'd1, 8'h00, q); chk("R11 end status", q, 8'hC0);
    bus(1'b0, 2'd2, 8'h00, q); chk("R5 received 44", q, 8'h44);
    bus(1'b0, 2'd1, 8'h00, q); chk("R11 cleared after end", q, 8'h00);

    // R4: serial clock period per rate code
    for (int r = 0; r < 4; r++) begin
      bus(1'b1, 2'd0, 8'(8'h80 | r), q);
      start_xfer(8'(8'hC0 + r), 8'(8'h0F + r));
      @(negedge sck); t0 = cyc;
      @(negedge sck);
      chk($sformatf("R4 period rate %0d", r), cyc - t0, 64 >> r);
      wait_all();
      bus(1'b0, 2'd2, 8'h00, q); chk("R5 received at rate", q, 8'(8'h0F + r));
      bus(1'b1, 2'd0, 8'h93, q);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule